// File: doc/BRIEF.md
# Seconds Counter with Interval Interrupt

This core keeps time as a plain binary count of seconds. A 32.768 kHz time-base enable, one clock cycle wide, is divided down inside the core to a once-per-second tick. Each tick advances a 32-bit seconds register. The register wraps to zero after all ones, which is about 136 years. A single control byte does two jobs. It starts and stops the time base, and it arms a periodic interrupt. The interval of that interrupt is picked from eight powers of two.

Software-facing logic outside the core uses three strobes. The first copies the running count into a snapshot register, so a multi-byte read never tears. The second writes the control byte, and the write acts at once. The third commits a previously staged 32-bit value into the seconds register. The interrupt output is active low. It pulses when a tick lands the count on a multiple of the selected interval. A freshly loaded time can therefore cause a pulse on the very next tick or only much later.

Top module: `sec_timekeeper`

## Requirements
- R1: While the oscillator is enabled, the seconds count rises by exactly one after every PRESCALE time-base enables, and at no other time.
- R2: Advancing from 0xFFFFFFFF gives 0x00000000.
- R3: While the oscillator is disabled, the count holds its value and the prescaler is held at zero. After a restart, a full PRESCALE enables pass before the next step.
- R4: `ctrl_rdata` is {interrupt enable, interval code[2:0], osc, osc, 2'b00} (bit 7 down to bit 0), and it reads 0x00 after reset.
- R5: A control write takes effect on the next clock. The oscillator state is taken from `ctrl_wdata[3]`, and `ctrl_wdata[2:0]` are ignored.
- R6: A `snap_req` copies the current count to `snap_data`. `snap_data` then does not change until the next `snap_req`, even while counting goes on.
- R7: `stage_wr` only fills a staging register and leaves the count as it is. `commit` loads the staged value into the count and wins over a same-cycle tick.
- R8: Interval codes 0..7 select 1, 4, 32, 64, 2048, 4096, 65536 and 131072 seconds. An interrupt starts on the tick whose new count is a multiple of the selected interval.
- R9: With the interrupt enable bit (control bit 7) at 0, no interrupt pulse starts.
- R10: An interrupt pulse drives `irq_n` low for exactly PULSE_LEN time-base enables.
- R11: After reset, the count is 0, `irq_n` is high, the oscillator is off and `snap_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz time-base enable, one clock wide |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| stage_wr | input | 1 | Staging register write strobe |
| stage_wdata | input | 32 | Value to stage for a later load |
| commit | input | 1 | Loads the staged value into the seconds count |
| snap_req | input | 1 | Copies the seconds count into the snapshot |
| ctrl_rdata | output | 8 | Control byte readback |
| snap_data | output | 32 | Snapshot of the seconds count |
| irq_n | output | 1 | Active-low interval interrupt pulse |

## Verification
The hardest cases to reach are the long intervals. With a 131072-second interval, waiting for the alignment from reset is out of reach. The bench instead stages and commits a count just below the boundary while the oscillator is stopped. It then starts the oscillator and checks `irq_n` on every cycle across the aligning tick. A shortened prescaler makes seconds a few clocks long. Every run is bracketed by an oscillator start and stop, so the exact number of ticks is known and the result can be read back through the snapshot.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef struct packed {
        logic       ie;
        logic [2:0] isel;
        logic       osc;
    } ctrl_t;

    // log2 of the interrupt interval in seconds for each select code
    function automatic int unsigned interval_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 5;
            3'd3:    return 6;
            3'd4:    return 11;
            3'd5:    return 12;
            3'd6:    return 16;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic osc_en,
    output logic sec_tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sec_tick = 1'b0;
        if (!osc_en) begin
            st_d.pre = '0;
        end else if (tick_en) begin
            if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                sec_tick = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a stopped oscillator leaves the divider at zero
    p_pre_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (st_q.pre == '0));

    // R1: no tick without an enabled oscillator and a time-base enable
    p_tick_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (osc_en && tick_en));

endmodule

// File: rtl/ts_irq_gen.sv
module ts_irq_gen
    import ts_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sec_tick,
    input  logic             ie,
    input  logic [2:0]       isel,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             irq_n
);
    localparam int LEN_W = $clog2(PULSE_LEN + 1);
    localparam logic [LEN_W-1:0] LEN_INIT = LEN_W'(PULSE_LEN);

    typedef struct packed {
        logic [LEN_W-1:0] left;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic             fire;

    always_comb begin
        mask = (CNT_W'(1) << interval_shift(isel)) - CNT_W'(1);
        fire = sec_tick && ie && ((cnt_next & mask) == '0);
        st_d = st_q;
        if (fire) begin
            st_d.left = LEN_INIT;
        end else if (tick_en && st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n = (st_q.left == '0);

    // R8: an aligned tick starts a pulse
    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !irq_n);

    // R9: an idle output stays idle while interrupts are disabled
    p_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !ie) |=> irq_n);

endmodule

// File: rtl/sec_timekeeper.sv
module sec_timekeeper
    import ts_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PRESCALE  = 32768,
    parameter int PULSE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             stage_wr,
    input  logic [CNT_W-1:0] stage_wdata,
    input  logic             commit,
    input  logic             snap_req,
    output logic [7:0]       ctrl_rdata,
    output logic [CNT_W-1:0] snap_data,
    output logic             irq_n
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] stage;
        logic [CNT_W-1:0] snap;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        sec_tick;
    logic [CNT_W-1:0] cnt_inc;
    logic        unused_wbits;

    assign unused_wbits = ^ctrl_wdata[2:0];

    ts_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .osc_en   (st_q.ctrl.osc),
        .sec_tick (sec_tick)
    );

    always_comb begin
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        if (ctrl_wr) begin
            st_d.ctrl.ie   = ctrl_wdata[7];
            st_d.ctrl.isel = ctrl_wdata[6:4];
            st_d.ctrl.osc  = ctrl_wdata[3];
        end
        if (stage_wr) st_d.stage = stage_wdata;
        if (commit)        st_d.cnt = st_q.stage;
        else if (sec_tick) st_d.cnt = cnt_inc;
        if (snap_req) st_d.snap = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ts_irq_gen #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .sec_tick (sec_tick),
        .ie       (st_q.ctrl.ie),
        .isel     (st_q.ctrl.isel),
        .cnt_next (cnt_inc),
        .irq_n    (irq_n)
    );

    assign ctrl_rdata = {st_q.ctrl.ie, st_q.ctrl.isel, st_q.ctrl.osc, st_q.ctrl.osc, 2'b00};
    assign snap_data  = st_q.snap;

    // R3: count frozen while the oscillator is off and nothing is loaded
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.osc && !commit) |=> $stable(st_q.cnt));

    // R1, R2: a tick advances the count by one, modulo 2^CNT_W
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !commit) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R7: a commit loads the staged value
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.cnt == $past(st_q.stage)));

    // R6: the snapshot only moves on a request
    p_snap_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_data));

endmodule

// File: tb/tb_sec_timekeeper.sv
`timescale 1ns/1ps
module tb_sec_timekeeper;
    localparam int PRESCALE  = 8;
    localparam int PULSE_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        stage_wr = 1'b0;
    logic [31:0] stage_wdata = '0;
    logic        commit = 1'b0;
    logic        snap_req = 1'b0;
    logic [7:0]  ctrl_rdata;
    logic [31:0] snap_data;
    logic        irq_n;

    always #2 clk = ~clk;

    sec_timekeeper #(.CNT_W(32), .PRESCALE(PRESCALE), .PULSE_LEN(PULSE_LEN)) dut (
        .clk, .rst_n, .tick_en, .ctrl_wr, .ctrl_wdata, .stage_wr, .stage_wdata,
        .commit, .snap_req, .ctrl_rdata, .snap_data, .irq_n
    );

    typedef struct {
        int          kind;   // 0 ctrl_rdata, 1 snap_data, 2 irq_n
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = {24'd0, ctrl_rdata};
                1:       act = snap_data;
                default: act = {31'd0, irq_n};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic op(input bit cw, input logic [7:0] cd, input bit sw,
                      input logic [31:0] sd, input bit cm, input bit sn);
        @(negedge clk);
        ctrl_wr = cw; ctrl_wdata = cd; stage_wr = sw; stage_wdata = sd;
        commit = cm; snap_req = sn;
        @(posedge clk);
        #1;
        ctrl_wr = 1'b0; stage_wr = 1'b0; commit = 1'b0; snap_req = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);  op(1'b1, v, 1'b0, '0, 1'b0, 1'b0); endtask
    task automatic load(input logic [31:0] v);
        op(1'b0, '0, 1'b1, v, 1'b0, 1'b0);
        op(1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
    endtask
    task automatic snap_chk(input logic [31:0] v, input string tag);
        op(1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
        push(1, v, tag);
    endtask
    // oscillator on, k more edges, oscillator off: floor((k+1)/PRESCALE) ticks
    task automatic run(input logic [7:0] on_val, input int k);
        wr_ctrl(on_val);
        repeat (k) @(posedge clk);
        wr_ctrl(8'h00);
    endtask
    // watch irq_n for n cycles after enabling; low on cycles [lo, lo+PULSE_LEN)
    task automatic irq_watch(input logic [7:0] on_val, input int n,
                             input int lo1, input int lo2, input string tag);
        wr_ctrl(on_val);
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #1;
            push(2, ((i >= lo1 && i < lo1 + PULSE_LEN) ||
                     (i >= lo2 && i < lo2 + PULSE_LEN)) ? 32'd0 : 32'd1, tag);
        end
        wr_ctrl(8'h00);
        repeat (PULSE_LEN + 2) @(posedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R11, R4: reset state
        push(0, 32'h00, "R4 reset ctrl");
        push(2, 32'd1, "R11 reset irq_n");
        push(1, 32'd0, "R11 reset snapshot");
        snap_chk(32'd0, "R11 reset count");

        // R5: bit 3 decides the oscillator, low bits ignored
        wr_ctrl(8'h08); push(0, 32'h0C, "R5 bit3 wins on");
        wr_ctrl(8'h07); push(0, 32'h00, "R5 bit3 wins off");
        wr_ctrl(8'h70); push(0, 32'h70, "R4 select readback");
        wr_ctrl(8'h00);

        // R7: staging alone does not change the count
        load(32'd100);
        op(1'b0, '0, 1'b1, 32'd555, 1'b0, 1'b0);
        snap_chk(32'd100, "R7 stage without commit");

        // R1: three seconds
        run(8'h0C, 8 * 3 - 1);
        snap_chk(32'd103, "R1 three seconds");

        // R6: snapshot stays while counting continues
        wr_ctrl(8'h0C);
        repeat (9) @(posedge clk);
        snap_chk(32'd104, "R6 snapshot taken");
        repeat (20) @(posedge clk); #1;
        push(1, 32'd104, "R6 snapshot stable");
        wr_ctrl(8'h00);

        // R3: hold while stopped
        load(32'd10);
        repeat (50) @(posedge clk);
        snap_chk(32'd10, "R3 hold when off");
        // R3: prescaler cleared by stop
        run(8'h0C, 4);
        run(8'h0C, 6);
        snap_chk(32'd10, "R3 prescaler restarted");
        run(8'h0C, 7);
        snap_chk(32'd11, "R1 one second after restart");

        // R2: wrap
        load(32'hFFFF_FFFF);
        run(8'h0C, 7);
        snap_chk(32'd0, "R2 wrap to zero");

        // R8, R10: 131072 s interval crossing
        load(32'd131070);
        irq_watch(8'hFC, 24, 16, 999, "R8 R10 interval 131072");
        // R9: same crossing, interrupts disabled
        load(32'd131070);
        irq_watch(8'h7C, 24, 999, 999, "R9 disabled");
        // R8: 4 s interval from count 1 fires at 4
        load(32'd1);
        irq_watch(8'h9C, 30, 24, 999, "R8 interval 4");
        // R8, R10: 1 s interval fires every tick
        load(32'd5);
        irq_watch(8'h8C, 20, 8, 16, "R8 interval 1");
        // R8: 2048 s interval
        load(32'd2046);
        irq_watch(8'hCC, 20, 16, 999, "R8 interval 2048");

        @(posedge clk); @(negedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule